// File: doc/BRIEF.md
# Per-Context Interrupt Priority Selector

For a single interrupt target context, this block looks at every interrupt source's pending flag, the context's enable mask, each source's priority and the context's threshold. It reports which source should be handed out on the next claim, that source's priority, and whether the context should be signalled that an external interrupt is waiting. It holds no configuration state of its own. The register file, the bus access path, the gateways and the claim side effects all live in neighbouring blocks, which feed this one and read its outputs.

Slot 0 is the "no interrupt" identifier and can never be selected. A priority of 0 removes a source from the contest. Among the remaining candidates the highest priority wins, and when priorities are equal the lower identifier wins. The threshold affects only the notification. The identifier offered for a claim is shown whatever the threshold is. A parameter adds a register stage after the selection, and that stage is on by default.

Top module: `ctx_prio_select`

## Requirements
- R1: Slot 0 is never selected. If the only pending and enabled source is slot 0, whatever its priority, then win_id and win_prio are 0.
- R2: A source competes only if its bit in src_pend is 1 and its bit in src_en is 1. A source that has only one of the two bits set has no effect on the outputs.
- R3: A source whose priority field is 0 never wins, even when it is pending and enabled.
- R4: Among the competing sources, the one with the numerically largest priority wins.
- R5: When several competing sources share the largest priority, the one with the smallest index wins.
- R6: If no source competes, win_id is 0, win_prio is 0 and irq_note is 0.
- R7: win_prio equals the priority field of the source reported in win_id. The priority of source i is carried in src_prio[i*PW +: PW].
- R8: irq_note is 1 exactly when win_prio is strictly greater than thresh. A threshold of 0 lets every nonzero priority through, and a threshold equal to the winner's priority masks it.
- R9: win_id and win_prio do not depend on thresh. A masked winner is still reported.
- R10: With OUT_REG=1, the outputs reflect the inputs sampled at the previous rising clock edge. A synchronous active-low reset drives all three outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous reset, active low |
| src_pend | input | N_SRC | Pending flag per source slot |
| src_en | input | N_SRC | This context's enable per source slot |
| src_prio | input | N_SRC*PW | Packed per-source priorities, slot i at [i*PW +: PW] |
| thresh | input | PW | This context's priority threshold |
| win_id | output | $clog2(N_SRC) | Index of the winning source, 0 if none |
| win_prio | output | PW | Priority of the winning source, 0 if none |
| irq_note | output | 1 | External-interrupt notification for the context |

## Verification
The hardest case to reach from the ports is a tie in which the two equal-priority candidates sit in different subtrees of the reduction. These include the last slot against a neighbour and a low slot against a high slot, while a higher-index source of lower priority is also present. Purely random stimulus seldom sets up such ties at the top node, so directed cases place equal priorities at chosen slot pairs. The random phase draws priorities from a narrow range so that ties are frequent, and it mixes sparse and dense pending and enable masks. A second set of directed cases sets the threshold equal to, one below and one above the winner's priority. These cases show the notification switching while the reported identifier stays the same.

// File: rtl/ctx_prio_pkg.sv
// Package: shared defaults for the per-context priority selector.
// Assumes: consumers override these through module parameters when needed.
package ctx_prio_pkg;
    localparam int unsigned DEF_N_SRC   = 32; // source slots, slot 0 reserved
    localparam int unsigned DEF_PW      = 3;  // priority field width
    localparam bit          DEF_OUT_REG = 1'b1;
endpackage

// File: rtl/prio_node.sv
// Module: prio_node
// Compares two (id, priority) pairs and passes on the stronger one.
// Assumes: the left input always carries lower ids than the right one, so a
// tie resolves to the left and the lowest id wins overall.
module prio_node #(
    parameter int unsigned PW = 3,
    parameter int unsigned IW = 5
) (
    input  logic [IW-1:0] l_id,
    input  logic [PW-1:0] l_pr,
    input  logic [IW-1:0] r_id,
    input  logic [PW-1:0] r_pr,
    output logic [IW-1:0] o_id,
    output logic [PW-1:0] o_pr
);
    logic take_r;

    // The right side wins only when its priority is strictly higher.
    always_comb begin
        take_r = (r_pr > l_pr);
        o_id   = take_r ? r_id : l_id;
        o_pr   = take_r ? r_pr : l_pr;
    end
endmodule

// File: rtl/prio_tree.sv
// Module: prio_tree
// Balanced reduction tree that finds the highest-priority live source.
// Assumes: N_SRC >= 2. Leaves past N_SRC and slot 0 are padded as empty
// (id 0, prio 0). A leaf that is not live, or whose priority is zero,
// reports id 0, so the root reads 0/0 when nothing competes.
module prio_tree #(
    parameter int unsigned N_SRC = 32,
    parameter int unsigned PW    = 3,
    parameter int unsigned IW    = 5
) (
    input  logic [N_SRC-1:0]    live,
    input  logic [N_SRC*PW-1:0] prio,
    output logic [IW-1:0]       root_id,
    output logic [PW-1:0]       root_pr
);
    localparam int unsigned LVL   = $clog2(N_SRC);
    localparam int unsigned LEAVES = 1 << LVL;
    localparam int unsigned NODES  = 2 * LEAVES - 1;

    logic [IW-1:0] nid [NODES];
    logic [PW-1:0] npr [NODES];

    // Leaf level: mask each slot by its live flag and remove the reserved slot.
    for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
        if (k != 0 && k < N_SRC) begin : g_real
            assign npr[LEAVES-1+k] = live[k] ? prio[k*PW +: PW] : '0;
            assign nid[LEAVES-1+k] = (npr[LEAVES-1+k] != '0) ? IW'(k) : '0;
        end else begin : g_pad
            assign npr[LEAVES-1+k] = '0;
            assign nid[LEAVES-1+k] = '0;
        end
    end

    // Internal levels: node i merges children 2i+1 (lower ids) and 2i+2.
    for (genvar i = 0; i < LEAVES - 1; i++) begin : g_node
        prio_node #(.PW(PW), .IW(IW)) u_node (
            .l_id (nid[2*i+1]),
            .l_pr (npr[2*i+1]),
            .r_id (nid[2*i+2]),
            .r_pr (npr[2*i+2]),
            .o_id (nid[i]),
            .o_pr (npr[i])
        );
    end

    assign root_id = nid[0];
    assign root_pr = npr[0];
endmodule

// File: rtl/note_stage.sv
// Module: note_stage
// Derives the notification from the winner and the threshold, with an
// optional output register.
// Assumes: synchronous active-low reset. The threshold masks only the
// notification, never the id or priority passed through.
module note_stage #(
    parameter int unsigned PW  = 3,
    parameter int unsigned IW  = 5,
    parameter bit          REG = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] id_i,
    input  logic [PW-1:0] pr_i,
    input  logic [PW-1:0] thr_i,
    output logic [IW-1:0] id_o,
    output logic [PW-1:0] pr_o,
    output logic          note_o
);
    logic note_c;

    // Strict comparison: equal priority and threshold masks the notification.
    assign note_c = (pr_i > thr_i);

    if (REG) begin : g_reg
        // Capture the winner and notification once per clock, cleared on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                id_o   <= '0;
                pr_o   <= '0;
                note_o <= 1'b0;
            end else begin
                id_o   <= id_i;
                pr_o   <= pr_i;
                note_o <= note_c;
            end
        end

        // R8: a raised notification implies the priority beat last cycle's threshold.
        p_note_above_thr_r8: assert property (@(posedge clk) disable iff (!rst_n)
            note_o |-> (pr_o > $past(thr_i)));
        // R10: the registered id follows the previous cycle's selection.
        p_id_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (id_o == $past(id_i)));
    end else begin : g_comb
        assign id_o   = id_i;
        assign pr_o   = pr_i;
        assign note_o = note_c;
    end
endmodule

// File: rtl/ctx_prio_select.sv
// Module: ctx_prio_select (top)
// Picks the pending, enabled source with the highest nonzero priority for
// one target context, breaking ties toward the lower id, and raises the
// notification when that priority is above the context threshold.
// Assumes: N_SRC >= 2. Slot 0 is reserved. src_prio slot i sits at [i*PW +: PW].
module ctx_prio_select
    import ctx_prio_pkg::*;
#(
    parameter int unsigned N_SRC   = DEF_N_SRC,
    parameter int unsigned PW      = DEF_PW,
    parameter bit          OUT_REG = DEF_OUT_REG,
    localparam int unsigned IW     = $clog2(N_SRC)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_SRC-1:0]    src_pend,
    input  logic [N_SRC-1:0]    src_en,
    input  logic [N_SRC*PW-1:0] src_prio,
    input  logic [PW-1:0]       thresh,
    output logic [IW-1:0]       win_id,
    output logic [PW-1:0]       win_prio,
    output logic                irq_note
);
    logic [N_SRC-1:0] cand_v;
    logic [IW-1:0]    root_id;
    logic [PW-1:0]    root_pr;
    logic             any_live;

    // A slot competes only when it is both pending and enabled.
    assign cand_v = src_pend & src_en;

    prio_tree #(.N_SRC(N_SRC), .PW(PW), .IW(IW)) u_tree (
        .live    (cand_v),
        .prio    (src_prio),
        .root_id (root_id),
        .root_pr (root_pr)
    );

    note_stage #(.PW(PW), .IW(IW), .REG(OUT_REG)) u_note (
        .clk    (clk),
        .rst_n  (rst_n),
        .id_i   (root_id),
        .pr_i   (root_pr),
        .thr_i  (thresh),
        .id_o   (win_id),
        .pr_o   (win_prio),
        .note_o (irq_note)
    );

    // Independent scan for the checks: is there any slot that could win?
    always_comb begin
        any_live = 1'b0;
        for (int i = 1; i < int'(N_SRC); i++) begin
            if (cand_v[i] && (src_prio[i*PW +: PW] != '0)) any_live = 1'b1;
        end
    end

    // R2: a reported winner must be pending and enabled.
    p_winner_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (root_id != '0) |-> cand_v[root_id]);
    // R1: a nonzero priority never comes with the reserved id.
    p_no_slot0_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (root_pr != '0) |-> (root_id != '0));
    // R7: the reported priority belongs to the reported source.
    p_prio_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (root_id != '0) |-> (root_pr == src_prio[root_id*PW +: PW]));
    // R3: a winner never has priority zero.
    p_nonzero_win_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (root_id != '0) |-> (root_pr != '0));
    // R6: with nothing live the selection is empty.
    p_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !any_live |-> (root_id == '0 && root_pr == '0));
    // R6: the notification never accompanies an empty selection.
    p_note_needs_id_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_note |-> (win_id != '0));
endmodule

// File: tb/sim_ctx_prio_select.sv
`timescale 1ns/1ps
module sim_ctx_prio_select;
    localparam int N  = 32;
    localparam int PW = 3;
    localparam int IW = $clog2(N);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      src_pend = '0;
    logic [N-1:0]      src_en = '0;
    logic [N*PW-1:0]   src_prio = '0;
    logic [PW-1:0]     thresh = '0;
    logic [IW-1:0]     win_id;
    logic [PW-1:0]     win_prio;
    logic              irq_note;

    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    ctx_prio_select u0 (
        .clk(clk), .rst_n(rst_n), .src_pend(src_pend), .src_en(src_en),
        .src_prio(src_prio), .thresh(thresh),
        .win_id(win_id), .win_prio(win_prio), .irq_note(irq_note)
    );

    task automatic check(input string tag, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // Reference: scan from slot 1 upward, replace only on strictly higher priority.
    function automatic void model(input logic [N-1:0] p, input logic [N-1:0] e,
                                  input logic [N*PW-1:0] pr, output int id, output int pv);
        id = 0; pv = 0;
        for (int i = 1; i < N; i++) begin
            if (p[i] && e[i] && int'(pr[i*PW +: PW]) > pv) begin
                id = i; pv = int'(pr[i*PW +: PW]);
            end
        end
    endfunction

    // Drive on a falling edge, wait one rising edge, compare at the next falling edge.
    task automatic apply(input string tag, input logic [N-1:0] p, input logic [N-1:0] e,
                         input logic [N*PW-1:0] pr, input logic [PW-1:0] t);
        int id, pv;
        src_pend = p; src_en = e; src_prio = pr; thresh = t;
        model(p, e, pr, id, pv);
        @(negedge clk);
        check(tag, "win_id", int'(win_id), id);
        check(tag, "win_prio", int'(win_prio), pv);
        check(tag, "irq_note", int'(irq_note), (pv > int'(t)) ? 1 : 0);
    endtask

    function automatic logic [N*PW-1:0] setp(input logic [N*PW-1:0] v, input int i, input int pr);
        logic [N*PW-1:0] r = v;
        r[i*PW +: PW] = PW'(pr);
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [N*PW-1:0] pr;
        void'($urandom(32'd20240611));
        // R10: reset clears outputs even with a live source present.
        src_pend = '1; src_en = '1; src_prio = '1;
        repeat (3) @(negedge clk);
        check("R10", "win_id reset", int'(win_id), 0);
        check("R10", "win_prio reset", int'(win_prio), 0);
        check("R10", "irq_note reset", int'(irq_note), 0);
        rst_n = 1'b1;

        // R1: only slot 0 pending and enabled.
        apply("R1", 32'h1, 32'h1, setp('0, 0, 7), 3'd0);
        // R2: pending without enable, and enable without pending.
        pr = setp(setp('0, 4, 5), 6, 6);
        apply("R2", 32'h10, 32'h40, pr, 3'd0);
        apply("R2", 32'h50, 32'h50, pr, 3'd0);
        // R3: live source with priority zero.
        apply("R3", 32'h0000_0100, 32'h0000_0100, setp('0, 8, 0), 3'd0);
        // R4: higher priority at a higher slot beats a lower one.
        pr = setp(setp('0, 5, 2), 20, 6);
        apply("R4", (32'h1 << 5) | (32'h1 << 20), '1, pr, 3'd0);
        // R5: ties across subtrees, low slot against high slot with a lesser rival.
        pr = setp(setp(setp('0, 3, 4), 9, 4), 30, 3);
        apply("R5", (32'h1 << 3) | (32'h1 << 9) | (32'h1 << 30), '1, pr, 3'd0);
        pr = setp(setp(setp('0, 16, 5), 31, 5), 1, 2);
        apply("R5", (32'h1 << 16) | (32'h1 << 31) | 32'h2, '1, pr, 3'd1);
        pr = setp(setp('0, 30, 7), 31, 7);
        apply("R5", 32'hC000_0000, '1, pr, 3'd0);
        // R6: nothing competes.
        apply("R6", '0, '1, '1, 3'd0);
        // R8 / R9: threshold equal, one below and above the winner's priority.
        pr = setp('0, 12, 4);
        apply("R8", 32'h1000, 32'h1000, pr, 3'd4);
        apply("R8", 32'h1000, 32'h1000, pr, 3'd3);
        apply("R9", 32'h1000, 32'h1000, pr, 3'd7);
        apply("R8", 32'h1000, 32'h1000, setp('0, 12, 1), 3'd0);
        // R7: random masks with narrow priorities to provoke ties.
        for (int it = 0; it < 400; it++) begin
            logic [N*PW-1:0] rp = '0;
            logic [N-1:0] rpend = $urandom;
            logic [N-1:0] ren = (it % 3 == 0) ? $urandom & $urandom : $urandom | $urandom;
            for (int s = 0; s < N; s++) rp = setp(rp, s, (it % 2) ? $urandom_range(0, 2) : $urandom_range(0, 7));
            apply("R7", rpend, ren, rp, PW'($urandom_range(0, 7)));
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule